// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a single countdown timer behind a small word-indexed register port. Software programs a reload limit, a control byte and an optional background limit. The counter then decrements once per prescaled tick and flags an expiry each time it reaches zero. The `tick_i` input is already slowed down from the system clock. On top of it the block applies its own divider of 1, 16 or 256.

Three counting behaviours are available. Periodic mode reloads from the programmed limit. One-shot mode stops at zero. Free-running mode is selected when neither mode bit is set: it ignores the programmed limit and wraps to the largest value the selected width can hold. The width is 16 or 32 bits. The expiry sets a raw flag. The interrupt output is that flag gated by an enable bit, and both the gated and ungated forms can be read back.

The register port is plain and synchronous. A write takes effect at the clock edge where `wr_en_i` is high. Read data follows `addr_i` combinationally, so the port has no valid/ready handshake and no back-pressure.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register reads 0x20 and raw status, masked status, load and value all read 0. `irq_o` is low.
- R2: Control bit positions are: bit0 one-shot, bit1 wide (1 = 32-bit, 0 = 16-bit), bits[3:2] prescaler code, bit5 interrupt enable, bit6 periodic, bit7 run enable. The control register reads back the written byte. When bit0 and bit6 are both set, the timer behaves as one-shot.
- R3: With the timer enabled and `tick_i` high, the counter steps once per tick for prescaler code 0 or 3, once per 16 ticks for code 1, and once per 256 ticks for code 2. With bit7 clear the counter does not move. The divider restarts from zero while the timer is disabled.
- R4: In periodic mode each step decrements the counter. The step that brings it to zero sets the raw flag. The next step reloads the limit.
- R5: In one-shot mode the counter stops at zero after setting the raw flag, and stays there until a load write.
- R6: In free-running mode a load write or a step from zero places 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit) in the counter. The programmed limit is not used for this, although it is still stored and read back.
- R7: A write to index 0 stores the limit and loads the counter in that same edge. If a step falls in the same cycle, the write wins.
- R8: A write to index 6 stores the limit only. The counter keeps counting and picks up the new limit at its next reload. Index 0 and index 6 both read the stored limit.
- R9: In 16-bit mode only the low 16 bits count and are compared with zero. The value register (index 1) reads them zero-extended, so loading 0x12345 reads back 0x2345.
- R10: `irq_o` is the raw flag ANDed with bit5. Masked status (index 5) reads 0 when bit5 is clear. Raw status (index 4) is not affected by bit5.
- R11: Any write to index 3 clears the raw flag. If an expiry happens in the same cycle, the flag stays set.
- R12: Writes to index 1 and to index 7 change nothing. Reads of index 3 and index 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Pre-divided count enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Masked interrupt level |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is an interrupt-clear write and the step that brings the counter to zero. The second pair is a load write and an ordinary step. The bench provokes each pair by driving `tick_i` and the write strobe together in one cycle. It then judges the result from the raw status, which must stay set, and from the value register, which must show the written limit rather than a decremented count. Sweeps over small limits and step counts in periodic and one-shot modes check every reload and stop point against closed-form arithmetic.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CTRL_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // Control byte layout; positions are software-visible.
  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } cdt_ctrl_t;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'd0,
    PRE_DIV16  = 2'd1,
    PRE_DIV256 = 2'd2,
    PRE_PASS   = 2'd3
  } cdt_pre_e;

  localparam int IDX_LOAD   = 0;
  localparam int IDX_VALUE  = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_CLR    = 3;
  localparam int IDX_RAW    = 4;
  localparam int IDX_MASKED = 5;
  localparam int IDX_BGLOAD = 6;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int LOG_A = 4,
  parameter int LOG_B = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  import cdt_pkg::*;

  logic [LOG_B-1:0] cnt_q;
  logic             hit_a, hit_b, pass;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_a = &cnt_q[LOG_A-1:0];
  assign hit_b = &cnt_q;

  always_comb begin
    case (cdt_pre_e'(sel_i))
      PRE_DIV16:  pass = hit_a;
      PRE_DIV256: pass = hit_b;
      default:    pass = 1'b1;
    endcase
  end

  assign step_o = run_i & tick_i & pass;

  // R3: at divide-by-16 two steps never come back to back
  p_div16_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && sel_i == 2'd1 && $stable(sel_i)) |=> !step_o);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         wide_i,
  input  logic         oneshot_i,
  input  logic         freerun_i,
  input  logic [W-1:0] limit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] value_o,
  output logic         expire_o
);
  localparam logic [W-1:0] NARROW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [W-1:0] ONE         = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, mask, cur, reload, load_val;

  assign mask     = wide_i ? '1 : NARROW_MASK;
  assign cur      = cnt_q & mask;
  assign reload   = freerun_i ? mask : (limit_i & mask);
  assign load_val = freerun_i ? mask : (load_data_i & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (step_i) begin
      if (cur == '0) cnt_q <= oneshot_i ? '0 : reload;
      else           cnt_q <= cur - ONE;
    end
  end

  assign value_o  = cur;
  assign expire_o = step_i & ~load_i & (cur == ONE);

  // R4: a plain step decrements by one unless the width changed
  p_decr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && cur != '0) |=>
      ((wide_i != $past(wide_i)) || value_o == $past(cur) - ONE));

  // R5: one-shot holds at zero
  p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && oneshot_i && cur == '0) |=> value_o == '0);
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic raw_o,
  output logic irq_o
);
  logic raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     raw_q <= 1'b0;
    else if (set_i) raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & ie_i;

  // R11: an expiry beats a clear in the same cycle
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> raw_o);
  // R11: a lone clear drops the flag
  p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !raw_o);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 16,
  parameter int ADDR_W    = cdt_pkg::ADDR_W,
  parameter int PRE_LOG_A = 4,
  parameter int PRE_LOG_B = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import cdt_pkg::*;

  cdt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] limit_q, value;
  logic wr_load, wr_ctrl, wr_clr, wr_bg;
  logic freerun, step, expire, raw;

  assign wr_load = wr_en_i && addr_i == ADDR_W'(IDX_LOAD);
  assign wr_ctrl = wr_en_i && addr_i == ADDR_W'(IDX_CTRL);
  assign wr_clr  = wr_en_i && addr_i == ADDR_W'(IDX_CLR);
  assign wr_bg   = wr_en_i && addr_i == ADDR_W'(IDX_BGLOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= cdt_ctrl_t'(CTRL_RESET);
      limit_q <= '0;
    end else begin
      if (wr_ctrl)         ctrl_q  <= cdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_load || wr_bg) limit_q <= wdata_i;
    end
  end

  assign freerun = ~ctrl_q.oneshot & ~ctrl_q.periodic;

  cdt_prescale #(.LOG_A(PRE_LOG_A), .LOG_B(PRE_LOG_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(ctrl_q.en),
    .sel_i(ctrl_q.pre), .step_o(step)
  );

  cdt_counter #(.W(DATA_W), .NW(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(step), .wide_i(ctrl_q.wide),
    .oneshot_i(ctrl_q.oneshot), .freerun_i(freerun), .limit_i(limit_q),
    .load_i(wr_load), .load_data_i(wdata_i), .value_o(value),
    .expire_o(expire)
  );

  cdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(expire), .clr_i(wr_clr),
    .ie_i(ctrl_q.ie), .raw_o(raw), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      IDX_LOAD, IDX_BGLOAD: rdata_o = limit_q;
      IDX_VALUE:            rdata_o = value;
      IDX_CTRL:             rdata_o = DATA_W'(ctrl_q);
      IDX_RAW:              rdata_o = DATA_W'(raw);
      IDX_MASKED:           rdata_o = DATA_W'(raw & ctrl_q.ie);
      default:              rdata_o = '0;
    endcase
  end

  // R12: the control byte only moves on its own index
  p_ctrl_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
  // R10: the output stays low while the enable bit is clear
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.ie |-> !irq_o);
endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'(idx); wdata_i = val;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    addr_i = 3'(idx);
    #1 v = rdata_o;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  // one tick together with one write in the same cycle
  task automatic tick_wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 3'(idx); wdata_i = val;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2, v); chk("R1 ctrl", v, 32'h20);
    rd(4, v); chk("R1 raw", v, 0);
    rd(5, v); chk("R1 masked", v, 0);
    rd(0, v); chk("R1 load", v, 0);
    rd(1, v); chk("R1 value", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R2 control read back
    wr(2, 32'h3C); rd(2, v); chk("R2 ctrl readback", v, 32'h3C);

    // R4 periodic sweep: value = L - k mod (L+1)
    wr(2, 32'hE2);
    for (int l = 1; l <= 5; l++) begin
      for (int k = 0; k <= 2*l + 2; k++) begin
        wr(3, 0); wr(0, l); run(k);
        rd(1, v); chk("R4 periodic value", v, 32'(l - (k % (l + 1))));
        rd(4, v); chk("R4 periodic raw", v, (k >= l) ? 1 : 0);
      end
    end

    // R5 one-shot sweep with periodic bit also set (R2 precedence)
    wr(2, 32'hE3);
    for (int l = 1; l <= 4; l++) begin
      for (int k = 0; k <= l + 3; k++) begin
        wr(3, 0); wr(0, l); run(k);
        rd(1, v); chk("R5 R2 oneshot value", v, (k >= l) ? 0 : 32'(l - k));
        rd(4, v); chk("R5 oneshot raw", v, (k >= l) ? 1 : 0);
      end
    end
    wr(0, 9); rd(1, v); chk("R5 reload after stop", v, 9);

    // R3 prescaler
    wr(2, 32'h00); wr(2, 32'hC6); wr(0, 100);
    run(15); rd(1, v); chk("R3 div16 early", v, 100);
    run(1);  rd(1, v); chk("R3 div16 step", v, 99);
    wr(2, 32'h00); wr(2, 32'hCA); wr(0, 100);
    run(255); rd(1, v); chk("R3 div256 early", v, 100);
    run(1);   rd(1, v); chk("R3 div256 step", v, 99);
    wr(2, 32'hCE); wr(0, 100);
    run(3); rd(1, v); chk("R3 code3 div1", v, 97);
    wr(2, 32'h42);
    run(5); rd(1, v); chk("R3 disabled holds", v, 97);

    // R6 free-running
    wr(2, 32'h80); wr(0, 7);
    rd(1, v); chk("R6 free16 load", v, 32'h0000_FFFF);
    rd(0, v); chk("R6 limit stored", v, 7);
    run(2); rd(1, v); chk("R6 free16 count", v, 32'h0000_FFFD);
    wr(2, 32'h82); wr(0, 7);
    rd(1, v); chk("R6 free32 load", v, 32'hFFFF_FFFF);
    wr(2, 32'hC0); wr(0, 1); run(1);
    wr(2, 32'h80); run(1);
    rd(1, v); chk("R6 free16 wrap", v, 32'h0000_FFFF);

    // R9 narrow width
    wr(2, 32'hC0); wr(0, 32'h12345);
    rd(1, v); chk("R9 narrow value", v, 32'h2345);
    rd(0, v); chk("R9 limit full", v, 32'h12345);
    run(1); rd(1, v); chk("R9 narrow step", v, 32'h2344);
    wr(2, 32'hC2); wr(0, 32'h12345);
    rd(1, v); chk("R9 wide value", v, 32'h12345);

    // R8 background load
    wr(0, 3); wr(6, 5);
    rd(1, v); chk("R8 value kept", v, 3);
    rd(0, v); chk("R8 idx0 reads limit", v, 5);
    rd(6, v); chk("R8 idx6 reads limit", v, 5);
    run(3); rd(1, v); chk("R8 reached zero", v, 0);
    run(1); rd(1, v); chk("R8 new reload", v, 5);

    // R7 load beats a step in the same cycle
    tick_wr(0, 40); rd(1, v); chk("R7 load vs step", v, 40);

    // R10 masking
    wr(2, 32'hC2); wr(3, 0); wr(0, 1); run(1);
    rd(4, v); chk("R10 raw with ie off", v, 1);
    rd(5, v); chk("R10 masked with ie off", v, 0);
    chk("R10 irq with ie off", {31'b0, irq_o}, 0);
    wr(2, 32'hE2);
    rd(5, v); chk("R10 masked with ie on", v, 1);
    chk("R10 irq with ie on", {31'b0, irq_o}, 1);

    // R11 clear, and clear colliding with expiry
    wr(3, 32'hDEAD);
    rd(4, v); chk("R11 clear", v, 0);
    chk("R11 irq cleared", {31'b0, irq_o}, 0);
    wr(0, 3); run(2);
    rd(4, v); chk("R11 not yet expired", v, 0);
    tick_wr(3, 0);
    rd(4, v); chk("R11 expiry beats clear", v, 1);
    rd(1, v); chk("R11 reached zero", v, 0);

    // R12 ignored writes and empty indices
    wr(0, 20);
    wr(1, 32'h1234); wr(7, 32'hFFFF_FFFF);
    rd(1, v); chk("R12 value untouched", v, 20);
    rd(0, v); chk("R12 limit untouched", v, 20);
    rd(2, v); chk("R12 ctrl untouched", v, 32'hE2);
    rd(7, v); chk("R12 idx7 reads zero", v, 0);
    rd(3, v); chk("R12 idx3 reads zero", v, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule